// File: doc/BRIEF.md
# Instruction Fetch Patch Unit

The unit sits between a CPU's instruction-fetch port and a read-only program store. Software loads up to four patch addresses and turns each one on with its own enable bit. Every valid fetch address is compared against the enabled entries. On a hit, the instruction word returned to the CPU is swapped for a fixed jump-to-zero word. This sends execution to the reset entry without any change to the program store.

On a hit, the unit also raises a sticky request flag for each matching channel. Startup code reads the flags. All zero means a true reset. A nonzero value means a patch entry, and the set bits name the channel or channels that caused it. Software clears each flag on its own by writing a 1 to that bit once the channel's handler has finished. Flags of several channels may be pending together, for example when a second patch fires while an earlier one is still being handled.

Top module: `fetch_patch_unit`

## Requirements
- R1: After an asynchronous reset (rst_ni low), every register reads zero: the four patch addresses (index 0..3), the enable register (index 4) and the flag register (index 5).
- R2: A write to index 0..3 loads that channel's patch address. Bit 0 is stored as 0, so a write of 32'h205 reads back as 32'h204.
- R3: Bits [3:0] of index 4 enable channels 3..0. A disabled channel never substitutes and never sets its flag, even when its address matches.
- R4: When fetch_valid_i is high and an enabled channel matches, fetch_rdata_o equals the jump word 32'h0000_0060 in the same cycle.
- R5: When no enabled channel matches, fetch_rdata_o equals fetch_rdata_i in the same cycle.
- R6: A hit on channel n sets bit n of the flag register (index 5). The bit reads 1 after the next rising clock edge.
- R7: Flags are sticky. Writing 1 to a bit of index 5 clears that bit. Writing 0 to a bit, or leaving the register idle, leaves the bit unchanged.
- R8: If a hit on channel n and a clear of bit n occur in the same cycle, bit n ends up 1. Other bits cleared in that cycle end up 0.
- R9: When several enabled channels match one fetch, all of their flags are set and a single jump word is returned.
- R10: Address bit 0 is excluded from the comparison. Fetches to 32'h100 and 32'h101 both hit a channel holding 32'h100.
- R11: With fetch_valid_i low, fetch_rdata_o equals fetch_rdata_i and no flag is set, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_idx_i | input | 3 | Register index (0..3 address, 4 enable, 5 flags) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_idx_i (combinational) |
| fetch_valid_i | input | 1 | Fetch beat valid |
| fetch_addr_i | input | 32 | Fetch address |
| fetch_rdata_i | input | 32 | Instruction word from program memory |
| fetch_rdata_o | output | 32 | Instruction word delivered to the CPU |

## Verification
The hardest case to reach is a hit and a flag clear landing on the same edge. This needs a register write and a matching fetch driven in the same cycle, with the flag already set. The bench first raises two flags with separate fetches. It then drives a clear of both bits together with a fetch that hits one of them, and expects only the hitting bit to survive. Multi-channel hits are reached by programming two channels to addresses that differ only in bit 0, which also exercises the masked low bit.

// File: rtl/fetch_patch_pkg.sv
package fetch_patch_pkg;
  localparam int unsigned NUM_CH    = 4;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned IDX_W     = 3;
  localparam logic [31:0] JUMP_WORD = 32'h0000_0060;
  localparam int unsigned EN_IDX    = NUM_CH;
  localparam int unsigned FLAG_IDX  = NUM_CH + 1;
endpackage

// File: rtl/patch_cfg_regs.sv
module patch_cfg_regs #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned EN_IDX = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic [ADDR_W-1:0]              wr_data_i,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  ch_addr_o,
  output logic [NUM_CH-1:0]              ch_en_o
);
  localparam logic [IDX_W-1:0] EN_SEL = IDX_W'(EN_IDX);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [IDX_W-1:0] SEL = IDX_W'(g);
    logic [ADDR_W-1:0] addr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         addr_q <= '0;
      else if (wr_en_i && wr_idx_i == SEL) addr_q <= {wr_data_i[ADDR_W-1:1], 1'b0};
    end
    assign ch_addr_o[g] = addr_q;
  end

  logic [NUM_CH-1:0] en_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            en_q <= '0;
    else if (wr_en_i && wr_idx_i == EN_SEL) en_q <= wr_data_i[NUM_CH-1:0];
  end
  assign ch_en_o = en_q;
endmodule

// File: rtl/patch_match.sv
module patch_match #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 32
) (
  input  logic                           fetch_valid_i,
  input  logic [ADDR_W-1:0]              fetch_addr_i,
  input  logic [NUM_CH-1:0][ADDR_W-1:0]  ch_addr_i,
  input  logic [NUM_CH-1:0]              ch_en_i,
  output logic [NUM_CH-1:0]              hit_o
);
  // alignment bit excluded from compare
  localparam logic [ADDR_W-1:0] CMP_MASK = ~ADDR_W'(1);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
    assign hit_o[g] = fetch_valid_i && ch_en_i[g] &&
                      (((fetch_addr_i ^ ch_addr_i[g]) & CMP_MASK) == '0);
  end
endmodule

// File: rtl/patch_flags.sv
module patch_flags #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] flags_o
);
  logic [NUM_CH-1:0] flags_q;

  // set has priority over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_i) | set_i;
  end
  assign flags_o = flags_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R6, R8: a hit always leaves its flag set
    assert_flag_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flags_q[g]);
    assert_flag_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_q[g] && !clr_i[g]) |=> flags_q[g]);
    assert_flag_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !flags_q[g]);
    assert_no_spurious_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flags_q[g] && !set_i[g]) |=> !flags_q[g]);
  end
endmodule

// File: rtl/fetch_patch_unit.sv
module fetch_patch_unit
  import fetch_patch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic [DATA_W-1:0] fetch_rdata_i,
  output logic [DATA_W-1:0] fetch_rdata_o
);
  localparam logic [IDX_W-1:0] EN_SEL   = IDX_W'(EN_IDX);
  localparam logic [IDX_W-1:0] FLAG_SEL = IDX_W'(FLAG_IDX);
  localparam logic [DATA_W-1:0] JUMP    = DATA_W'(JUMP_WORD);

  logic [NUM_CH-1:0][ADDR_W-1:0] ch_addr;
  logic [NUM_CH-1:0]             ch_en;
  logic [NUM_CH-1:0]             hit;
  logic [NUM_CH-1:0]             flags;
  logic [NUM_CH-1:0]             clr;

  patch_cfg_regs #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .EN_IDX(EN_IDX)
  ) i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (reg_wr_i),
    .wr_idx_i  (reg_idx_i),
    .wr_data_i (reg_wdata_i),
    .ch_addr_o (ch_addr),
    .ch_en_o   (ch_en)
  );

  patch_match #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_match (
    .fetch_valid_i (fetch_valid_i),
    .fetch_addr_i  (fetch_addr_i),
    .ch_addr_i     (ch_addr),
    .ch_en_i       (ch_en),
    .hit_o         (hit)
  );

  assign clr = (reg_wr_i && reg_idx_i == FLAG_SEL) ? reg_wdata_i[NUM_CH-1:0] : '0;

  patch_flags #(.NUM_CH(NUM_CH)) i_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (hit),
    .clr_i   (clr),
    .flags_o (flags)
  );

  // substitution is combinational: no added wait state
  assign fetch_rdata_o = (|hit) ? JUMP : fetch_rdata_i;

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (reg_idx_i == IDX_W'(i)) reg_rdata_o = ch_addr[i];
    if (reg_idx_i == EN_SEL)   reg_rdata_o = ADDR_W'(ch_en);
    if (reg_idx_i == FLAG_SEL) reg_rdata_o = ADDR_W'(flags);
  end

  assert_jump_on_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit) |-> fetch_rdata_o == JUMP);
  assert_pass_no_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|hit) |-> fetch_rdata_o == fetch_rdata_i);
  assert_idle_pass_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |-> (fetch_rdata_o == fetch_rdata_i && hit == '0));
  assert_disabled_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit & ~ch_en) == '0);
endmodule

// File: tb/test_fetch_patch_unit.sv
module test_fetch_patch_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        f_valid = 1'b0;
  logic [31:0] f_addr = '0;
  logic [31:0] f_din = '0;
  logic [31:0] f_dout;

  localparam logic [31:0] JMP = 32'h0000_0060;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fetch_patch_unit i_fetch_patch_unit (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_idx_i(reg_idx),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .fetch_valid_i(f_valid),
    .fetch_addr_i(f_addr), .fetch_rdata_i(f_din), .fetch_rdata_o(f_dout)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] din;
    logic [31:0] dout;
    logic [3:0]  flg;
  } vec_t;

  // ch0=0x100 ch1=0x204 ch2=0x300 enabled, ch3=0x400 disabled
  localparam vec_t VEC [7] = '{
    '{32'h100, 32'hAAAA_0001, 32'h0000_0060, 4'b0001},  // R4 R6
    '{32'h101, 32'hAAAA_0002, 32'h0000_0060, 4'b0001},  // R10
    '{32'h104, 32'hAAAA_0003, 32'hAAAA_0003, 4'b0000},  // R5
    '{32'h204, 32'hAAAA_0004, 32'h0000_0060, 4'b0010},  // R6
    '{32'h300, 32'hAAAA_0005, 32'h0000_0060, 4'b0100},  // R6
    '{32'h400, 32'hAAAA_0006, 32'hAAAA_0006, 4'b0000},  // R3
    '{32'h000, 32'hAAAA_0007, 32'hAAAA_0007, 4'b0000}   // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_idx = idx;
    #1 d = reg_rdata;
  endtask

  task automatic fetch(input logic v, input logic [31:0] a, input logic [31:0] din,
                       output logic [31:0] dout);
    @(negedge clk);
    f_valid = v; f_addr = a; f_din = din;
    #1 dout = f_dout;
    @(negedge clk);
    f_valid = 1'b0;
  endtask

  function automatic string rtag(input int k);
    return $sformatf("R%0d", k);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, o;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      reg_read(3'(i), rd);
      chk(rtag(1), rd, 32'h0);
    end
    // R3: reset channels hold 0 but are disabled
    fetch(1'b1, 32'h0, 32'h1234_5678, o);
    chk("R3 disabled at reset", o, 32'h1234_5678);

    reg_write(3'd0, 32'h100);
    reg_write(3'd1, 32'h204);
    reg_write(3'd2, 32'h301);
    reg_write(3'd3, 32'h400);
    reg_read(3'd2, rd);
    chk("R2 bit0 dropped", rd, 32'h300);
    reg_read(3'd1, rd);
    chk("R2 readback", rd, 32'h204);
    reg_write(3'd4, 32'h7);
    reg_read(3'd4, rd);
    chk("R3 enable readback", rd, 32'h7);

    for (int i = 0; i < 7; i++) begin
      fetch(1'b1, VEC[i].addr, VEC[i].din, o);
      chk($sformatf("R4/R5 vec %0d out", i), o, VEC[i].dout);
      reg_read(3'd5, rd);
      chk($sformatf("R6 vec %0d flags", i), rd, {28'h0, VEC[i].flg});
      reg_write(3'd5, 32'hF);
      reg_read(3'd5, rd);
      chk($sformatf("R7 vec %0d cleared", i), rd, 32'h0);
    end

    // R11: no valid, no effect
    fetch(1'b0, 32'h100, 32'hBEEF_0001, o);
    chk("R11 out", o, 32'hBEEF_0001);
    reg_read(3'd5, rd);
    chk("R11 flags", rd, 32'h0);

    // R9: ch3 and ch1 both hit 0x204
    reg_write(3'd3, 32'h205);
    reg_read(3'd3, rd);
    chk("R2 ch3 readback", rd, 32'h204);
    reg_write(3'd4, 32'hF);
    fetch(1'b1, 32'h204, 32'hBEEF_0002, o);
    chk("R9 single jump", o, JMP);
    reg_read(3'd5, rd);
    chk("R9 flags", rd, 32'hA);

    // R7 sticky, write of 0 ignored, per-bit clear
    repeat (4) @(negedge clk);
    reg_read(3'd5, rd);
    chk("R7 sticky idle", rd, 32'hA);
    reg_write(3'd5, 32'h0);
    reg_read(3'd5, rd);
    chk("R7 zero write", rd, 32'hA);
    reg_write(3'd5, 32'h2);
    reg_read(3'd5, rd);
    chk("R7 single clear", rd, 32'h8);
    reg_write(3'd5, 32'h8);

    // R8 set beats clear
    fetch(1'b1, 32'h100, 32'h0, o);
    fetch(1'b1, 32'h300, 32'h0, o);
    reg_read(3'd5, rd);
    chk("R8 precondition", rd, 32'h5);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = 3'd5; reg_wdata = 32'h5;
    f_valid = 1'b1; f_addr = 32'h100; f_din = 32'hBEEF_0003;
    #1 chk("R8 jump during clear", f_dout, JMP);
    @(negedge clk);
    reg_wr = 1'b0; f_valid = 1'b0;
    reg_read(3'd5, rd);
    chk("R8 set wins", rd, 32'h1);

    // R3: disabling ch0 stops its hit
    reg_write(3'd5, 32'hF);
    reg_write(3'd4, 32'hE);
    fetch(1'b1, 32'h100, 32'hBEEF_0004, o);
    chk("R3 disabled out", o, 32'hBEEF_0004);
    reg_read(3'd5, rd);
    chk("R3 disabled flag", rd, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule